// File: doc/BRIEF.md
# Up-Counting Timer with Buffered Prescaler

This block is a general-purpose timer that counts upward from zero. Its rate comes from a prescaler divider, and its period comes from a reload limit. Software reaches it through a plain address, write-data and write-enable port. Every register reads back through a registered data output.

Software writes land in preload registers. The divider and the counter run from separate active copies. Those copies are refreshed only on an update event. An update event has two sources: the counter wrapping past its limit, or a software strobe.

The prescaler copy is always buffered this way. The reload copy is buffered only when a control bit asks for it. Every update event raises a sticky status flag. A level interrupt output follows that flag, gated by an enable bit. Update events, the flag and the interrupt all keep working while counting is stopped.

Top module: `tmr_upcount`

## Requirements
- R1: A value written to the prescaler register (address 3) does not change the counting rate until the next update event. The update event copies it into the active divider.
- R2: After reset, the active divider is 0, so the counter advances on every clock while running. This holds until the first update event, whichever source causes it.
- R3: Bit 1 of the control register (address 0) selects reload buffering. When it is 1, a write to the reload register (address 4) takes effect only at the next update event. When it is 0, the written value becomes the active limit on the clock edge of the write.
- R4: Writing 1 to bit 0 of the event register (address 2) causes an update event on that clock edge. The update event loads the active copies, and it restarts both the divider and the counter from 0. Address 2 always reads back as 0.
- R5: Every update event sets the status flag, which is bit 0 of address 2's neighbour, address 1. Writing 0 to that bit clears the flag. Writing 1 to it has no effect. When a set and a clear meet in the same cycle, the set wins.
- R6: The irq output is high in exactly the cycles where the status flag and the interrupt enable (control bit 2) are both 1. With the enable at 0, irq stays low.
- R7: Control bit 0 only starts and stops counting. While it is 0, the divider and the counter hold their values. A software update event still loads the copies, clears the counter and sets the flag.
- R8: While running, the counter advances once every (active divider + 1) clocks. When a tick finds the counter at or above the active limit, the counter wraps to 0 and raises an update event.
- R9: With an active limit of 0, the counter stays at 0 and raises an update event on every divider tick while running.
- R10: Reset clears the control bits, the flag, the prescaler register, the counter, rdata and irq. It sets the reload register and the active limit to all ones. The counter value reads at address 5. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 3 | Register select for writes and read-back |
| wdata | input | DATA_W | Write data |
| we | input | 1 | Write enable, one write per cycle |
| rdata | output | DATA_W | Registered read data for the address seen at the previous edge |
| irq | output | 1 | Level interrupt, the status flag gated by its enable |

## Verification
The embedded properties take reset to be held for at least one clock edge. They also take addr to always carry a defined code. Beyond that they assume nothing about write timing, so collisions between a clear write and a wrap are legal stimulus.

The stimulus drives only defined register codes, and changes inputs only on falling edges. It deliberately repeats flag-clearing writes across a natural wrap, so that the set-over-clear priority is exercised. It also never writes a preload register in the same cycle as a forced update, because the ordering of those two is not among the stated requirements.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [2:0] {
    SEL_CTRL = 3'd0,
    SEL_STAT = 3'd1,
    SEL_EVT  = 3'd2,
    SEL_PSC  = 3'd3,
    SEL_RLD  = 3'd4,
    SEL_CNT  = 3'd5
  } reg_sel_e;

  localparam int CTRL_RUN_BIT  = 0;
  localparam int CTRL_BUF_BIT  = 1;
  localparam int CTRL_IEN_BIT  = 2;
  localparam int CTRL_BITS     = 3;
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int PSC_W  = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              we,
  input  logic              upd,
  input  logic [CNT_W-1:0]  cnt_val,
  output logic              run,
  output logic              rld_buf,
  output logic [PSC_W-1:0]  psc_pre,
  output logic [CNT_W-1:0]  rld_pre,
  output logic              sw_upd,
  output logic              rld_imm_wr,
  output logic [CNT_W-1:0]  rld_imm_data,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  logic wr_ctrl, wr_stat, wr_psc, wr_rld;
  logic run_q, buf_q, ien_q, flag_q, irq_q;
  logic flag_d, ien_d;
  logic [PSC_W-1:0]  psc_q;
  logic [CNT_W-1:0]  rld_q;
  logic [DATA_W-1:0] rd_mux, rdata_q;

  assign wr_ctrl = we && (addr == SEL_CTRL);
  assign wr_stat = we && (addr == SEL_STAT);
  assign wr_psc  = we && (addr == SEL_PSC);
  assign wr_rld  = we && (addr == SEL_RLD);

  assign sw_upd       = we && (addr == SEL_EVT) && wdata[0];
  assign rld_imm_wr   = wr_rld && !buf_q;
  assign rld_imm_data = wdata[CNT_W-1:0];

  always_comb begin
    if (upd)                       flag_d = 1'b1;
    else if (wr_stat && !wdata[0]) flag_d = 1'b0;
    else                           flag_d = flag_q;
  end

  assign ien_d = wr_ctrl ? wdata[CTRL_IEN_BIT] : ien_q;

  always_comb begin
    rd_mux = '0;
    case (addr)
      SEL_CTRL: rd_mux = DATA_W'({ien_q, buf_q, run_q});
      SEL_STAT: rd_mux = DATA_W'(flag_q);
      SEL_PSC:  rd_mux = DATA_W'(psc_q);
      SEL_RLD:  rd_mux = DATA_W'(rld_q);
      SEL_CNT:  rd_mux = DATA_W'(cnt_val);
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q   <= 1'b0;
      buf_q   <= 1'b0;
      ien_q   <= 1'b0;
      flag_q  <= 1'b0;
      irq_q   <= 1'b0;
      psc_q   <= '0;
      rld_q   <= '1;
      rdata_q <= '0;
    end else begin
      if (wr_ctrl) begin
        run_q <= wdata[CTRL_RUN_BIT];
        buf_q <= wdata[CTRL_BUF_BIT];
      end
      ien_q   <= ien_d;
      flag_q  <= flag_d;
      irq_q   <= flag_d && ien_d;
      if (wr_psc) psc_q <= wdata[PSC_W-1:0];
      if (wr_rld) rld_q <= wdata[CNT_W-1:0];
      rdata_q <= rd_mux;
    end
  end

  assign run     = run_q;
  assign rld_buf = buf_q;
  assign psc_pre = psc_q;
  assign rld_pre = rld_q;
  assign rdata   = rdata_q;
  assign irq     = irq_q;

  // R5: an update event always leaves the flag set
  p_flag_set_r5: assert property (@(posedge clk) disable iff (rst)
    upd |=> flag_q);
  // R5: a clear write without a competing update clears the flag
  p_flag_clear_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_stat && !wdata[0] && !upd) |=> !flag_q);
  // R6: interrupt only while flag and enable are both held
  p_irq_gated_r6: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> (flag_q && ien_q));
  // R4: event register reads as zero
  p_evt_reads_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (addr == SEL_EVT) |=> (rdata_q == '0));
endmodule

// File: rtl/tmr_presc.sv
module tmr_presc #(
  parameter int PSC_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             upd,
  input  logic [PSC_W-1:0] psc_pre,
  output logic             tick
);
  logic [PSC_W-1:0] div_q, psc_act_q;

  assign tick = run && (div_q == psc_act_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q     <= '0;
      psc_act_q <= '0;
    end else if (upd) begin
      div_q     <= '0;
      psc_act_q <= psc_pre;
    end else if (tick) begin
      div_q     <= '0;
    end else if (run) begin
      div_q     <= div_q + 1'b1;
    end
  end

  // R1: the active divider changes only on an update event
  p_psc_hold_r1: assert property (@(posedge clk) disable iff (rst)
    !upd |=> $stable(psc_act_q));
  // R8: divider never runs past the active value
  p_div_range_r8: assert property (@(posedge clk) disable iff (rst)
    div_q <= psc_act_q);
  // R7: divider is frozen while stopped and no update occurs
  p_div_frozen_r7: assert property (@(posedge clk) disable iff (rst)
    (!run && !upd) |=> $stable(div_q));
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             upd,
  input  logic             rld_buf,
  input  logic [CNT_W-1:0] rld_pre,
  input  logic             rld_imm_wr,
  input  logic [CNT_W-1:0] rld_imm_data,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  logic [CNT_W-1:0] cnt_q, lim_q;

  assign wrap = tick && (cnt_q >= lim_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      lim_q <= '1;
    end else begin
      if (upd)       cnt_q <= '0;
      else if (tick) cnt_q <= cnt_q + 1'b1;
      if (upd && rld_buf) lim_q <= rld_pre;
      else if (rld_imm_wr) lim_q <= rld_imm_data;
    end
  end

  assign cnt = cnt_q;

  // R4: any update event leaves the counter at zero
  p_upd_zero_r4: assert property (@(posedge clk) disable iff (rst)
    upd |=> (cnt_q == '0));
  // R7: counter holds without a tick or update
  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!tick && !upd) |=> $stable(cnt_q));
  // R9: a zero limit pins the counter at zero
  p_zero_limit_r9: assert property (@(posedge clk) disable iff (rst)
    ((cnt_q == '0) && (lim_q == '0) && !rld_imm_wr) |=> (cnt_q == '0));
endmodule

// File: rtl/tmr_upcount.sv
module tmr_upcount
  import tmr_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int PSC_W  = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              we,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  logic             run, rld_buf, sw_upd, rld_imm_wr, tick, wrap, upd;
  logic [PSC_W-1:0] psc_pre;
  logic [CNT_W-1:0] rld_pre, rld_imm_data, cnt;

  assign upd = sw_upd || wrap;

  tmr_regs #(.DATA_W(DATA_W), .PSC_W(PSC_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .we(we),
    .upd(upd), .cnt_val(cnt), .run(run), .rld_buf(rld_buf),
    .psc_pre(psc_pre), .rld_pre(rld_pre), .sw_upd(sw_upd),
    .rld_imm_wr(rld_imm_wr), .rld_imm_data(rld_imm_data),
    .rdata(rdata), .irq(irq)
  );

  tmr_presc #(.PSC_W(PSC_W)) u_presc (
    .clk(clk), .rst(rst), .run(run), .upd(upd),
    .psc_pre(psc_pre), .tick(tick)
  );

  tmr_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst(rst), .tick(tick), .upd(upd),
    .rld_buf(rld_buf), .rld_pre(rld_pre), .rld_imm_wr(rld_imm_wr),
    .rld_imm_data(rld_imm_data), .cnt(cnt), .wrap(wrap)
  );
endmodule

// File: tb/sim_tmr_upcount.sv
`timescale 1ns/1ps
module sim_tmr_upcount;
  localparam int W = 16;
  localparam int MASK = 65535;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [2:0]   addr = 3'd5;
  logic [W-1:0] wdata = '0;
  logic         we = 1'b0;
  logic [W-1:0] rdata;
  logic         irq;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit model_live = 1'b0;
  string cur_req = "R10";

  int m_run, m_buf, m_ien, m_flag, m_pscpre, m_rldpre;
  int m_pscact, m_lim, m_div, m_cnt, m_rd, m_irq;

  always #2.5 clk = ~clk;

  tmr_upcount #(.DATA_W(W), .PSC_W(W), .CNT_W(W)) u0 (
    .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .we(we),
    .rdata(rdata), .irq(irq)
  );

  // behavioural reference, advanced once per rising edge
  always @(posedge clk) begin
    int a, d, rd, tick, upd, sw;
    a = int'(addr);
    d = int'(wdata);
    if (rst) begin
      m_run = 0; m_buf = 0; m_ien = 0; m_flag = 0;
      m_pscpre = 0; m_rldpre = MASK; m_pscact = 0; m_lim = MASK;
      m_div = 0; m_cnt = 0; m_rd = 0; m_irq = 0;
    end else begin
      case (a)
        0: rd = m_run + 2 * m_buf + 4 * m_ien;
        1: rd = m_flag;
        3: rd = m_pscpre;
        4: rd = m_rldpre;
        5: rd = m_cnt;
        default: rd = 0;
      endcase
      sw   = (we && a == 2 && (d % 2) == 1) ? 1 : 0;
      tick = (m_run == 1 && m_div == m_pscact) ? 1 : 0;
      upd  = (sw == 1 || (tick == 1 && m_cnt >= m_lim)) ? 1 : 0;
      if (upd == 1) begin
        m_div = 0; m_cnt = 0; m_pscact = m_pscpre;
        if (m_buf == 1) m_lim = m_rldpre;
        else if (we && a == 4) m_lim = d;
      end else begin
        if (tick == 1) begin m_div = 0; m_cnt = (m_cnt + 1) & MASK; end
        else if (m_run == 1) m_div = (m_div + 1) & MASK;
        if (we && a == 4 && m_buf == 0) m_lim = d;
      end
      if (upd == 1) m_flag = 1;
      else if (we && a == 1 && (d % 2) == 0) m_flag = 0;
      if (we && a == 0) begin
        m_run = d % 2; m_buf = (d / 2) % 2; m_ien = (d / 4) % 2;
      end
      if (we && a == 3) m_pscpre = d;
      if (we && a == 4) m_rldpre = d;
      m_rd  = rd;
      m_irq = m_flag * m_ien;
    end
    model_live = 1'b1;
  end

  // compare on every falling edge
  always @(negedge clk) begin
    if (model_live) begin
      checks++;
      if (int'(rdata) != m_rd) begin
        fails++;
        $display("FAIL %s rdata actual=%0d expected=%0d t=%0t", cur_req, rdata, m_rd, $time);
      end
      checks++;
      if (int'(irq) != m_irq) begin
        fails++;
        $display("FAIL %s irq actual=%0d expected=%0d t=%0t", cur_req, irq, m_irq, $time);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 20000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=<20000 cycles", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    addr = 3'(a); wdata = W'(d); we = 1'b1;
    @(negedge clk);
    we = 1'b0; addr = 3'd5;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd_exp(input int a, input int exp, input string tag);
    @(negedge clk);
    addr = 3'(a);
    @(negedge clk);
    checks++;
    if (int'(rdata) != exp) begin
      fails++;
      $display("FAIL %s readback addr=%0d actual=%0d expected=%0d", tag, a, rdata, exp);
    end
    addr = 3'd5;
  endtask

  initial begin
    idle(4);
    checks++;
    if (rdata !== '0 || irq !== 1'b0) begin
      fails++;
      $display("FAIL R10 reset outputs actual=%0d/%0d expected=0/0", rdata, irq);
    end
    rst = 1'b0;
    rd_exp(4, MASK, "R10");
    rd_exp(3, 0, "R10");
    rd_exp(0, 0, "R10");
    rd_exp(7, 0, "R10");

    cur_req = "R2";
    wr(3, 3);             // R1: preload only
    wr(0, 1);             // run
    idle(12);
    rd_exp(3, 3, "R1");

    cur_req = "R4";
    wr(2, 1);             // forced update while running
    rd_exp(2, 0, "R4");
    idle(10);

    cur_req = "R5";
    wr(1, 1);             // writing 1 leaves flag
    rd_exp(1, 1, "R5");
    wr(1, 0);
    rd_exp(1, 0, "R5");

    cur_req = "R3";
    wr(4, 5);             // unbuffered limit: immediate
    wr(0, 5);             // run + irq enable
    cur_req = "R8";
    idle(60);

    cur_req = "R6";
    wr(1, 0);
    idle(5);
    cur_req = "R5";
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      addr = 3'd1; wdata = '0; we = 1'b1;
    end
    @(negedge clk);
    we = 1'b0; addr = 3'd5;

    cur_req = "R3";
    wr(0, 7);             // buffered reload
    wr(4, 2);
    idle(40);
    rd_exp(4, 2, "R3");

    cur_req = "R7";
    wr(0, 6);             // stop
    idle(10);
    wr(3, 0);
    wr(1, 0);
    idle(3);
    wr(2, 1);             // forced update while stopped
    idle(6);

    cur_req = "R6";
    wr(0, 0);             // enable off, buffer off
    wr(1, 0);
    wr(2, 1);
    idle(4);

    cur_req = "R9";
    wr(4, 0);
    wr(3, 1);
    wr(2, 1);
    wr(0, 5);
    idle(12);
    wr(1, 0);
    idle(6);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule